// File: doc/BRIEF.md
# Color Transform Matrix Stage

This stage sits in a display pixel pipeline just ahead of the gamma lookup. Each pixel carries a display-channel tag. When the tag matches the single channel currently selected, the pixel's red, green and blue components are multiplied by a programmable 3x3 matrix. All other pixels pass through untouched. The stage has one enable for the whole pipeline, so only one display channel at a time gets the transform.

Coefficients are ten-bit sign-magnitude fractions with no integer part, so every term has a gain below one. Software writes the coefficient and select registers at any time. The writes land in shadow copies, and these move to the working set only on a frame-start pulse, so no frame is processed with a mix of old and new settings. Pixels flow through a fixed two-stage pipeline with a valid/ready handshake on both sides. The channel tag travels with each pixel.

Top module: `ctm_stage`

## Requirements
- R1: For a selected pixel, each output component o equals round(sum over input k of comp_k * c_k,o / 512). Rounding is half-up: floor((sum + 256) / 512).
- R2: A rounded result below 0 is output as 0. A result above 255 is output as 255.
- R3: A coefficient has bit 9 as its sign (1 = negative) and bits 8:0 as its magnitude in units of 1/512. A negative sign with zero magnitude acts as zero.
- R4: Register address 0 holds the terms taken from red input, address 1 those from green input, and address 2 those from blue input. In each of these registers, bits 9:0 feed the red output, bits 19:10 the green output and bits 29:20 the blue output. Address 3 bits 2:0 hold the channel select.
- R5: A select value of 0 bypasses every channel. A value n+1 transforms channel n only. Pixels of other channels, and every pixel under a select value that matches no channel, pass through unchanged.
- R6: Register writes do not affect pixels until a frame-start pulse copies all four shadow registers to the working set. A write in the same cycle as the pulse applies only at the following pulse.
- R7: A bypassed pixel leaves bit-exact with its tag. An accepted pixel appears on the output registers after the second rising edge counted from its acceptance edge when the output is not stalled.
- R8: in_ready is high exactly when the output register is empty or is being taken. While out_valid is high and out_ready is low, the output stays unchanged. Pixels leave in order, none lost or repeated.
- R9: After reset, out_valid is 0 and the working coefficients and select are 0, so every pixel is bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse that loads the shadow registers into the working set |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel |
| in_pixel | input | 24 | Input pixel: red in 23:16, green in 15:8, blue in 7:0 |
| in_chan | input | 2 | Display channel of the input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pixel | output | 24 | Output pixel, same packing as the input |
| out_chan | output | 2 | Display channel of the output pixel |

## Verification
The bench sweeps component values around the rounding and saturation points against several matrices. One matrix has a distinct value in each of the nine coefficient positions, so a swapped field or a swapped register shows up as a wrong component. Negative-zero coefficients, all-negative matrices and select values beyond the last channel are covered. A design that treated the sign as two's complement, truncated instead of rounding, or wrapped on overflow would miscompare in these sweeps. The bench also writes a register in the same cycle as the frame pulse, which exposes a design that forwards the new value early. Random throttling on both handshakes checks that a stalled output holds and that no pixel is dropped or duplicated.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int MAG_W  = 9;
  localparam int COEF_W = MAG_W + 1;
  localparam int NCOMP  = 3;
  localparam int NCOEF  = NCOMP * NCOMP;
  localparam int NREG   = NCOMP + 1;
  localparam int RA_W   = $clog2(NREG);

  typedef struct packed {
    logic             sgn;
    logic [MAG_W-1:0] mag;
  } coef_t;
endpackage

// File: rtl/ctm_regs.sv
module ctm_regs
  import ctm_pkg::*;
#(
  parameter int CH_W = 2,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [RA_W-1:0]         addr,
  input  logic [DW-1:0]           wdata,
  input  logic                    frame_start,
  output coef_t [NCOEF-1:0]       act_coef,
  output logic [CH_W:0]           act_sel
);
  coef_t [NCOEF-1:0] sh_coef;
  logic [CH_W:0]     sh_sel;

  // shadow set: index = input_component * NCOMP + output_component
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_coef <= '0;
      sh_sel  <= '0;
    end else if (we) begin
      for (int i = 0; i < NCOMP; i++) begin
        if (addr == RA_W'(i)) begin
          for (int o = 0; o < NCOMP; o++) begin
            sh_coef[i*NCOMP+o] <= coef_t'(wdata[o*COEF_W +: COEF_W]);
          end
        end
      end
      if (addr == RA_W'(NCOMP)) begin
        sh_sel <= wdata[CH_W:0];
      end
    end
  end

  // working set moves only at frame boundaries
  always_ff @(posedge clk) begin
    if (rst) begin
      act_coef <= '0;
      act_sel  <= '0;
    end else if (frame_start) begin
      act_coef <= sh_coef;
      act_sel  <= sh_sel;
    end
  end

  p_act_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(act_coef) && $stable(act_sel)));

  p_frame_copy_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (act_coef == $past(sh_coef) && act_sel == $past(sh_sel)));
endmodule

// File: rtl/ctm_dot.sv
module ctm_dot
  import ctm_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                        clk,
  input  logic                        adv,
  input  logic                        en_in,
  input  logic [NCOMP-1:0][PIX_W-1:0] comp,
  input  coef_t [NCOMP-1:0]           coef,
  input  logic [PIX_W-1:0]            pass_in,
  output logic [PIX_W-1:0]            res
);
  localparam int PW = PIX_W + MAG_W + 1;
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (MAG_W - 1));
  localparam logic signed [SW-1:0] MAXV = SW'(2 ** PIX_W - 1);

  logic signed [PW-1:0] prod_c  [NCOMP];
  logic signed [PW-1:0] prod_s1 [NCOMP];
  logic                 en_s1;
  logic [PIX_W-1:0]     pass_s1;

  for (genvar k = 0; k < NCOMP; k++) begin : g_term
    logic [PIX_W+MAG_W-1:0] umag;
    always_comb begin
      umag      = comp[k] * coef[k].mag;
      prod_c[k] = coef[k].sgn ? -$signed({1'b0, umag}) : $signed({1'b0, umag});
    end
    always_ff @(posedge clk) begin
      if (adv) prod_s1[k] <= prod_c[k];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      en_s1   <= en_in;
      pass_s1 <= pass_in;
    end
  end

  logic signed [SW-1:0] sum, rsum, quot;
  logic [PIX_W-1:0]     sat;

  always_comb begin
    sum = '0;
    for (int k = 0; k < NCOMP; k++) begin
      sum = sum + SW'(prod_s1[k]);
    end
    rsum = sum + HALF;
    quot = rsum >>> MAG_W;
    if (rsum[SW-1])       sat = '0;
    else if (quot > MAXV) sat = '1;
    else                  sat = quot[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (adv) res <= en_s1 ? sat : pass_s1;
  end
endmodule

// File: rtl/ctm_stage.sv
module ctm_stage
  import ctm_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int CH_W  = 2,
  parameter int DW    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [RA_W-1:0]        reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  input  logic                   frame_start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NCOMP*PIX_W-1:0] in_pixel,
  input  logic [CH_W-1:0]        in_chan,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NCOMP*PIX_W-1:0] out_pixel,
  output logic [CH_W-1:0]        out_chan
);
  coef_t [NCOEF-1:0] act_coef;
  logic [CH_W:0]     act_sel;

  ctm_regs #(.CH_W(CH_W), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .frame_start(frame_start),
    .act_coef   (act_coef),
    .act_sel    (act_sel)
  );

  logic adv;
  logic hit;
  logic s1_valid;
  logic [CH_W-1:0] s1_chan;
  logic [NCOMP-1:0][PIX_W-1:0] in_comp;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign hit      = (act_sel != '0) && (act_sel == ({1'b0, in_chan} + (CH_W+1)'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_chan  <= in_chan;
      out_chan <= s1_chan;
    end
  end

  // component k: 0 = red (most significant), NCOMP-1 = blue
  for (genvar k = 0; k < NCOMP; k++) begin : g_split
    assign in_comp[k] = in_pixel[(NCOMP-1-k)*PIX_W +: PIX_W];
  end

  for (genvar o = 0; o < NCOMP; o++) begin : g_col
    coef_t [NCOMP-1:0] col;
    logic [PIX_W-1:0]  res;
    for (genvar k = 0; k < NCOMP; k++) begin : g_pick
      assign col[k] = act_coef[k*NCOMP+o];
    end
    ctm_dot #(.PIX_W(PIX_W)) u_dot (
      .clk    (clk),
      .adv    (adv),
      .en_in  (hit),
      .comp   (in_comp),
      .coef   (col),
      .pass_in(in_comp[o]),
      .res    (res)
    );
    assign out_pixel[(NCOMP-1-o)*PIX_W +: PIX_W] = res;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_chan)));

  p_no_phantom_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(s1_valid));
endmodule

// File: tb/sim_ctm_stage.sv
`timescale 1ns/1ps
module sim_ctm_stage;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        frame_start;
  logic        in_valid;
  logic        in_ready;
  logic [23:0] in_pixel;
  logic [1:0]  in_chan;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_pixel;
  logic [1:0]  out_chan;

  ctm_stage u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .in_chan(in_chan), .out_valid(out_valid),
    .out_ready(out_ready), .out_pixel(out_pixel), .out_chan(out_chan)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] sh  [4];
  logic [31:0] act [4];

  logic [23:0] inq_pix [$];
  logic [1:0]  inq_ch  [$];
  logic [23:0] exp_pix [$];
  logic [1:0]  exp_ch  [$];
  string       exp_lb  [$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic int cval(input int i, input int o);
    logic [9:0] b;
    b = act[i][o*10 +: 10];
    return b[9] ? -int'(b[8:0]) : int'(b[8:0]);
  endfunction

  function automatic logic [23:0] model(input logic [23:0] px, input logic [1:0] ch,
                                        output string lb);
    logic [2:0]  sel;
    logic [23:0] r;
    sel = act[3][2:0];
    lb  = "R5";
    if (sel == 3'd0 || sel != {1'b0, ch} + 3'd1) return px;
    lb = "R1";
    for (int o = 0; o < 3; o++) begin
      int s, v;
      s = 0;
      for (int k = 0; k < 3; k++) s += int'(px[(2-k)*8 +: 8]) * cval(k, o);
      s = s + 256;
      if (s < 0) begin v = 0; lb = "R2"; end
      else begin
        v = s / 512;
        if (v > 255) begin v = 255; lb = "R2"; end
      end
      r[(2-o)*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic ok, input logic [31:0] got,
                       input logic [31:0] want);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, want);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    sh[a] = d;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < 4; i++) act[i] = sh[i];
  endtask

  task automatic wr_and_frame(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; frame_start = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; frame_start = 1'b0;
    for (int i = 0; i < 4; i++) act[i] = sh[i];
    sh[a] = d;
  endtask

  function automatic logic [31:0] pack3(input int c0, input int c1, input int c2);
    return {2'b00, 10'(c2), 10'(c1), 10'(c0)};
  endfunction

  function automatic int enc(input int v);
    return v < 0 ? (512 | (-v)) : v;
  endfunction

  task automatic load_matrix(input int m [9]);
    for (int i = 0; i < 3; i++) wr(2'(i), pack3(enc(m[i*3]), enc(m[i*3+1]), enc(m[i*3+2])));
  endtask

  task automatic push(input logic [23:0] p, input logic [1:0] c);
    inq_pix.push_back(p);
    inq_ch.push_back(c);
  endtask

  task automatic drain(input int mode, input string req);
    int   guard;
    logic stall;
    logic [23:0] hp;
    logic [1:0]  hc;
    guard = 0;
    stall = 1'b0;
    hp = '0;
    hc = '0;
    while ((inq_pix.size() > 0 || exp_pix.size() > 0) && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (stall) check("R8", out_valid && out_pixel == hp && out_chan == hc,
                       {6'd0, out_chan, out_pixel}, {6'd0, hc, hp});
      in_valid = (inq_pix.size() > 0) && (mode == 0 || ($urandom % 4) != 0);
      if (in_valid) begin in_pixel = inq_pix[0]; in_chan = inq_ch[0]; end
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
      #1;
      if (out_valid && out_ready) begin
        if (exp_pix.size() == 0) begin
          check("R8", 1'b0, {6'd0, out_chan, out_pixel}, 32'hx);
        end else begin
          string lb;
          lb = {req, "/", exp_lb[0]};
          check(lb, out_pixel == exp_pix[0] && out_chan == exp_ch[0],
                {6'd0, out_chan, out_pixel}, {6'd0, exp_ch[0], exp_pix[0]});
          void'(exp_pix.pop_front()); void'(exp_ch.pop_front()); void'(exp_lb.pop_front());
        end
      end
      stall = out_valid && !out_ready;
      hp = out_pixel;
      hc = out_chan;
      if (in_valid && in_ready) begin
        string lb;
        exp_pix.push_back(model(inq_pix[0], inq_ch[0], lb));
        exp_ch.push_back(inq_ch[0]);
        exp_lb.push_back(lb);
        void'(inq_pix.pop_front()); void'(inq_ch.pop_front());
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    if (guard >= 20000) check("R8", 1'b0, guard, 0);
  endtask

  task automatic sweep(input logic [1:0] chan_mask_fixed, input logic fixed);
    int vals [8] = '{0, 1, 3, 127, 128, 200, 254, 255};
    int n;
    n = 0;
    for (int r = 0; r < 8; r++)
      for (int g = 0; g < 8; g++)
        for (int b = 0; b < 8; b++) begin
          push({8'(vals[r]), 8'(vals[g]), 8'(vals[b])}, fixed ? chan_mask_fixed : 2'(n));
          n++;
        end
  endtask

  initial begin
    int m [9];
    rst = 1'b1; reg_we = 0; reg_addr = 0; reg_wdata = 0; frame_start = 0;
    in_valid = 0; in_pixel = 0; in_chan = 0; out_ready = 1;
    for (int i = 0; i < 4; i++) begin sh[i] = 0; act[i] = 0; end
    repeat (4) @(negedge clk);
    check("R9", out_valid == 1'b0, out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9", out_valid == 1'b0 && in_ready == 1'b1, {out_valid, in_ready}, 2'b01);

    // R9: select 0 after reset, everything bypassed
    for (int c = 0; c < 4; c++) push(24'h13_57_9B + 24'(c), 2'(c));
    drain(0, "R9");

    // R6: shadow writes without a frame pulse have no effect
    m = '{256, 0, 0, 0, 256, 0, 0, 0, 256};
    load_matrix(m);
    wr(2'd3, 32'd1);
    for (int c = 0; c < 4; c++) push(24'hFF_81_03, 2'(c));
    drain(0, "R6");
    frame();
    // R1 rounding: half-gain diagonal on channel 0
    sweep(2'd0, 1'b1);
    drain(0, "R1");

    // R7: latency and bypass exactness
    @(negedge clk);
    in_valid = 1; in_pixel = 24'hA5_5A_C3; in_chan = 2'd2; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R7", out_valid == 1'b0, out_valid, 0);
    @(negedge clk);
    check("R7", out_valid == 1'b1 && out_pixel == 24'hA5_5A_C3 && out_chan == 2'd2,
          {out_valid, 5'd0, out_chan, out_pixel}, {1'b1, 5'd0, 2'd2, 24'hA5_5A_C3});
    @(negedge clk);
    check("R7", out_valid == 1'b0, out_valid, 0);

    // R4 field positions: distinct signed coefficient in each slot
    m = '{37, -74, 111, -148, 185, -222, 259, -296, 333};
    load_matrix(m);
    frame();
    sweep(2'd0, 1'b1);
    drain(1, "R4");

    // R2 saturation high and low
    m = '{511, 511, 511, 511, 511, 511, 511, 511, 511};
    load_matrix(m); frame(); sweep(2'd0, 1'b1); drain(1, "R2");
    m = '{-511, -300, -1, -2, -511, -77, -128, -256, -511};
    load_matrix(m); frame(); sweep(2'd0, 1'b1); drain(1, "R2");

    // R3: negative zero behaves as zero
    for (int i = 0; i < 3; i++) wr(2'(i), pack3(512, 512, 512));
    frame(); sweep(2'd0, 1'b1); drain(0, "R3");

    // R1: mixed matrix, near-unity permutation
    m = '{0, 511, 0, 0, 0, 511, 511, 0, 0};
    load_matrix(m); frame(); sweep(2'd0, 1'b1); drain(1, "R1");
    m = '{300, -120, 45, 90, 400, -60, -200, 150, 480};
    load_matrix(m); frame(); sweep(2'd0, 1'b1); drain(1, "R1");

    // R5: every select value against every channel
    for (int s = 0; s < 8; s++) begin
      wr(2'd3, 32'(s));
      frame();
      for (int c = 0; c < 4; c++) begin
        push(24'hC8_40_10, 2'(c));
        push(24'h05_FE_80, 2'(c));
      end
      drain(0, "R5");
    end

    // R6: write in the same cycle as the frame pulse applies one frame later
    wr(2'd3, 32'd2);
    frame();
    wr_and_frame(2'd3, 32'd0);
    for (int c = 0; c < 4; c++) push(24'hC8_40_10, 2'(c));
    drain(0, "R6");
    frame();
    for (int c = 0; c < 4; c++) push(24'hC8_40_10, 2'(c));
    drain(0, "R6");

    // R8: random throttling on both sides
    wr(2'd3, 32'd3);
    frame();
    for (int i = 0; i < 1500; i++) push(24'($urandom), 2'($urandom));
    drain(1, "R8");
    for (int i = 0; i < 1500; i++) push(24'($urandom), 2'($urandom));
    drain(2, "R8");

    repeat (3) @(negedge clk);
    check("R8", out_valid == 1'b0, out_valid, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule